// File: doc/BRIEF.md
# Hitless Reference-Switch Sequencer

This block controls how a clock-multiplying loop recovers when its reference is lost or replaced, so that the output clock moves gently. After the loop has shown lock for a run of consecutive cycles, the sequencer arms. A loss-of-lock event then turns the phase detector off and forces narrow loop bandwidth. If feedback edge realignment is enabled, the block works out a whole number of oscillator cycles to slip the feedback divider, so that the feedback edge nearest the new reference phase is used. It holds that slip for a fixed number of cycles, turns the detector back on and waits for lock again. Once lock is qualified, it runs a resume timer, returns to wide bandwidth and re-arms.

States are named idle, armed, hold, build, relock and timing. The transitions are: idle to armed on qualified lock; armed to hold on loss; hold to build (realignment on) or to relock (realignment off); build to relock when the build window ends; relock to timing on qualified lock; timing to armed when the timer expires. A loss event seen in hold, build, relock or timing sends the sequencer to hold. The narrow-bandwidth pin forces narrow bandwidth whatever the state. Loop dynamics are outside this block.

Top module: `hitless_seq`

## Requirements
- R1: After reset the status is idle (0), the detector enable is high, the slip enable is low, the slip amount is 0 and the bandwidth output equals the narrow-bandwidth pin.
- R2: The sequencer leaves idle for armed only after LOCK_CYCLES consecutive in-tolerance samples, and a gap in the run restarts the count. A loss event in idle has no effect.
- R3: A loss event in armed moves the status to hold on the next cycle. In hold the detector enable is low and the bandwidth output is narrow (1).
- R4: The slip amount is round-half-up(offset / OSC_PERIOD) modulo FB_DIV, with offset taken in picoseconds. It is captured while in hold and stays constant until the next hold.
- R5: With realignment on, hold lasts one cycle and build lasts BUILD_CYCLES cycles, with slip enable high and detector enable low. With realignment off, hold goes straight to relock and slip enable stays low.
- R6: In relock the detector enable is high and bandwidth stays narrow. Timing starts once LOCK_CYCLES consecutive in-tolerance samples are counted after the detector comes back on. Relock therefore lasts LOCK_CYCLES+1 cycles when the input stays in tolerance.
- R7: Timing lasts RESUME_CLKS cycles (175 ns at the default clock). The next state is armed, and the bandwidth output goes back to the pin value.
- R8: A loss event during build, relock or timing moves the status to hold on the next cycle.
- R9: The bandwidth output is 1 in every state while the narrow-bandwidth pin is high.
- R10: Status encoding: idle 0, armed 1, hold 2, build 3, relock 4, timing 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loss_evt | input | 1 | Loss-of-lock event, sampled every cycle |
| in_tol | input | 1 | Reference and feedback edges within tolerance this cycle |
| nbw_pin | input | 1 | Narrow-bandwidth request pin |
| pbo_en | input | 1 | Enables whole-cycle feedback realignment |
| phase_ofs | input | OFS_W | Measured reference-to-feedback offset in ps |
| pd_en | output | 1 | Phase detector enable |
| bw_narrow | output | 1 | Effective bandwidth select, 1 = narrow |
| slip_en | output | 1 | Feedback divider slip request |
| slip_amt | output | SLIP_W | Slip in oscillator cycles |
| status | output | 3 | Current state code |

## Verification
On every cycle, the embedded assertions check the following: the step from armed and recovery states to hold on loss, the detector being off in hold, the pin forcing narrow bandwidth, the direct hold-to-relock path when realignment is off, and that relock never ends without qualified lock. Window lengths, slip rounding at half-cycle boundaries, a lock run broken by a gap, and the return to wide bandwidth after the timer can only be shown by the bench's scenarios. In those scenarios a behavioural model predicts every output on every clock.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_HOLD   = 3'd2,
        ST_BUILD  = 3'd3,
        ST_RELOCK = 3'd4,
        ST_TIMING = 3'd5
    } hs_state_e;
endpackage

// File: rtl/hs_lock_qual.sv
module hs_lock_qual #(
    parameter int LOCK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_tol,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] TOP = CW'(LOCK_CYCLES);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run <= '0;
        else if (clr || !in_tol)   run <= '0;
        else if (run != TOP)       run <= run + 1'b1;
    end

    assign locked = (run == TOP);

    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run <= TOP);
endmodule

// File: rtl/hs_delay.sv
module hs_delay #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    a_r7_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/hs_slip_calc.sv
module hs_slip_calc #(
    parameter int OFS_W     = 16,
    parameter int OSC_PS    = 1600,
    parameter int FB_DIV    = 8,
    parameter int SLIP_W    = 3
) (
    input  logic [OFS_W-1:0]  phase_ofs,
    output logic [SLIP_W-1:0] slip
);
    localparam logic [OFS_W:0] HALF = (OFS_W+1)'(OSC_PS / 2);
    localparam logic [OFS_W:0] PER  = (OFS_W+1)'(OSC_PS);
    localparam logic [OFS_W:0] DIV  = (OFS_W+1)'(FB_DIV);

    logic [OFS_W:0] rounded;
    logic [OFS_W:0] edges;
    logic [OFS_W:0] wrapped;

    always_comb begin
        rounded = {1'b0, phase_ofs} + HALF;
        edges   = rounded / PER;
        wrapped = edges % DIV;
        slip    = wrapped[SLIP_W-1:0];
    end
endmodule

// File: rtl/hitless_seq.sv
module hitless_seq
    import hs_pkg::*;
#(
    parameter int OFS_W        = 16,
    parameter int OSC_PS       = 1600,
    parameter int FB_DIV       = 8,
    parameter int LOCK_CYCLES  = 8,
    parameter int BUILD_CYCLES = 4,
    parameter int RESUME_CLKS  = 35,
    localparam int SLIP_W      = $clog2(FB_DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loss_evt,
    input  logic              in_tol,
    input  logic              nbw_pin,
    input  logic              pbo_en,
    input  logic [OFS_W-1:0]  phase_ofs,
    output logic              pd_en,
    output logic              bw_narrow,
    output logic              slip_en,
    output logic [SLIP_W-1:0] slip_amt,
    output logic [2:0]        status
);
    hs_state_e state, state_nx;
    logic locked, build_done, resume_done, detector_off;
    logic [SLIP_W-1:0] slip_calc, slip_q;

    assign detector_off = (state == ST_HOLD) || (state == ST_BUILD);

    hs_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .clr(detector_off),
        .in_tol(in_tol), .locked(locked));

    hs_delay #(.LIMIT(BUILD_CYCLES)) u_build_win (
        .clk(clk), .rst_n(rst_n), .run(state == ST_BUILD), .done(build_done));

    hs_delay #(.LIMIT(RESUME_CLKS)) u_resume_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == ST_TIMING), .done(resume_done));

    hs_slip_calc #(.OFS_W(OFS_W), .OSC_PS(OSC_PS), .FB_DIV(FB_DIV),
                   .SLIP_W(SLIP_W)) u_slip (
        .phase_ofs(phase_ofs), .slip(slip_calc));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (locked) state_nx = ST_ARMED;
            ST_ARMED:  if (loss_evt) state_nx = ST_HOLD;
            ST_HOLD:   if (!loss_evt) state_nx = pbo_en ? ST_BUILD : ST_RELOCK;
            ST_BUILD:  if (loss_evt) state_nx = ST_HOLD;
                       else if (build_done) state_nx = ST_RELOCK;
            ST_RELOCK: if (loss_evt) state_nx = ST_HOLD;
                       else if (locked) state_nx = ST_TIMING;
            ST_TIMING: if (loss_evt) state_nx = ST_HOLD;
                       else if (resume_done) state_nx = ST_ARMED;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            slip_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_HOLD) slip_q <= slip_calc;
        end
    end

    always_comb begin
        pd_en     = !detector_off;
        slip_en   = (state == ST_BUILD);
        slip_amt  = slip_q;
        status    = state;
        bw_narrow = nbw_pin || (state == ST_HOLD) || (state == ST_BUILD) ||
                    (state == ST_RELOCK) || (state == ST_TIMING);
    end

    a_r3_armed_loss_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1) && loss_evt |=> (status == 3'd2));
    a_r3_hold_detector_off: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd2) |-> (!pd_en && bw_narrow));
    a_r9_pin_forces_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        nbw_pin |-> bw_narrow);
    a_r5_skip_build: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd2) && !pbo_en && !loss_evt |=> (status == 3'd4) && !slip_en);
    a_r8_loss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (status >= 3'd3) && loss_evt |=> (status == 3'd2));
    a_r6_relock_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd4) && !locked |=> (status != 3'd5));
    a_r2_idle_exit_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0) |=> (status <= 3'd1));
endmodule

// File: tb/test_hitless_seq.sv
`timescale 1ns/1ps
module test_hitless_seq;
    localparam int LOCKN = 8, BUILDN = 4, RESUMEN = 35;

    logic clk = 0, rst_n = 0;
    logic loss_evt = 0, in_tol = 0, nbw_pin = 0, pbo_en = 0;
    logic [15:0] phase_ofs = '0;
    logic pd_en, bw_narrow, slip_en;
    logic [2:0] slip_amt, status;

    int checks = 0, errors = 0;
    int m_st = 0, m_run = 0, m_cnt = 0, m_slip = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hitless_seq i_hitless_seq (
        .clk(clk), .rst_n(rst_n), .loss_evt(loss_evt), .in_tol(in_tol),
        .nbw_pin(nbw_pin), .pbo_en(pbo_en), .phase_ofs(phase_ofs),
        .pd_en(pd_en), .bw_narrow(bw_narrow), .slip_en(slip_en),
        .slip_amt(slip_amt), .status(status));

    function automatic int slip_of(int ofs);
        return ((ofs + 800) / 1600) % 8;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_cnt = 0; m_slip = 0;
        end else begin
            automatic int old = m_st;
            automatic bit lk = (m_run >= LOCKN);
            case (old)
                0: if (lk) m_st = 1;
                1: if (loss_evt) m_st = 2;
                2: begin
                    m_slip = slip_of(int'(phase_ofs));
                    if (!loss_evt) begin m_st = pbo_en ? 3 : 4; m_cnt = 0; end
                end
                3: if (loss_evt) m_st = 2;
                   else if (m_cnt == BUILDN-1) m_st = 4; else m_cnt++;
                4: if (loss_evt) m_st = 2;
                   else if (lk) begin m_st = 5; m_cnt = 0; end
                5: if (loss_evt) m_st = 2;
                   else if (m_cnt == RESUMEN-1) m_st = 1; else m_cnt++;
                default: m_st = 0;
            endcase
            if (old == 2 || old == 3) m_run = 0;
            else if (in_tol) m_run = (m_run < LOCKN) ? m_run + 1 : LOCKN;
            else m_run = 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        chk("R10 status", status, m_st);
        chk("R3 pd_en", pd_en, (m_st == 2 || m_st == 3) ? 0 : 1);
        chk("R9 bw_narrow", bw_narrow, (nbw_pin || m_st >= 2) ? 1 : 0);
        chk("R5 slip_en", slip_en, (m_st == 3) ? 1 : 0);
        chk("R4 slip_amt", slip_amt, m_slip);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic span(int s, output int n);
        n = 0;
        while (status == 3'(s) && n < 1000) begin n++; @(negedge clk); end
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        cyc(3);
        chk("R1 reset status", status, 0); chk("R1 reset pd_en", pd_en, 1);
        chk("R1 reset slip_en", slip_en, 0); chk("R1 reset slip", slip_amt, 0);
        chk("R1 reset bw", bw_narrow, 0);
        rst_n = 1; cyc(2);
        loss_evt = 1; cyc(1); loss_evt = 0; cyc(1);
        chk("R2 loss in idle ignored", status, 0);
        in_tol = 1; cyc(7); in_tol = 0; cyc(1); in_tol = 1; cyc(8);
        chk("R2 broken run not armed", status, 0);
        cyc(1); chk("R2 armed after run", status, 1);
        // realignment on, offset 5000 ps -> 3 cycles
        pbo_en = 1; phase_ofs = 16'd5000; loss_evt = 1; cyc(1); loss_evt = 0;
        chk("R3 hold after loss", status, 2); chk("R3 pd off", pd_en, 0);
        chk("R3 narrow", bw_narrow, 1);
        cyc(1); span(3, n); chk("R5 build length", n, BUILDN);
        chk("R4 slip 5000ps", slip_amt, 3);
        span(4, n); chk("R6 relock length", n, LOCKN + 1);
        span(5, n); chk("R7 timing length", n, RESUMEN);
        chk("R7 back to armed", status, 1); chk("R7 wide again", bw_narrow, 0);
        // half-cycle rounding and wrap: 13600 ps -> 9 mod 8 = 1
        phase_ofs = 16'd13600; loss_evt = 1; cyc(1); loss_evt = 0; cyc(2);
        chk("R4 slip rounds half up and wraps", slip_amt, 1);
        // loss during build restarts
        loss_evt = 1; cyc(1); loss_evt = 0;
        chk("R8 loss in build", status, 2);
        cyc(1); span(3, n); span(4, n); cyc(5);
        chk("R6 in timing", status, 5);
        loss_evt = 1; cyc(1); loss_evt = 0;
        chk("R8 loss in timing", status, 2);
        // realignment off, offset 799 ps -> 0
        pbo_en = 0; phase_ofs = 16'd799; cyc(1);
        chk("R5 skip build", status, 4); chk("R5 no slip", slip_en, 0);
        chk("R4 slip below half", slip_amt, 0);
        in_tol = 0; cyc(3); in_tol = 1; cyc(3);
        chk("R6 gap delays lock", status, 4);
        loss_evt = 1; cyc(1); loss_evt = 0;
        chk("R8 loss in relock", status, 2);
        nbw_pin = 1; cyc(1); span(4, n); span(5, n);
        chk("R9 pin narrow in armed", bw_narrow, 1);
        cyc(3); nbw_pin = 0; cyc(1);
        chk("R7 wide when pin low", bw_narrow, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule